// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

This block is a 32-pin general-purpose I/O port. Software reaches it through a word-wide register bus with address, write data, write strobe, read strobe and read data. Each pin can be driven from an output register when its direction bit selects output. The pad level of every pin is always brought into the clock domain through a two-flop synchroniser and can be read back.

Every pin also feeds an interrupt detector. A 2-bit trigger field per pin selects low level, high level, rising edge or falling edge. A separate per-pin both-edge bit overrides that field. Detected events set sticky status bits, which software clears by writing ones. A per-pin enable mask gates the status onto three lines: one for the lower half of the pins, one for the upper half, and one that combines both.

Top module: `gpio_port_irq`

## Requirements
- R1: While reset is held, every register reads zero, `pad_oe` and `pad_out` are zero and all three interrupt outputs are low.
- R2: A write at byte offset 0x00 loads the output register and a write at 0x04 loads the direction register. `pad_out` follows the output register and `pad_oe` follows the direction register (1 = output). Reading 0x00 or 0x04 returns the stored register and never the pad.
- R3: Reading offset 0x08 returns the pad inputs through a two-flop synchroniser, for every pin whatever its direction. A pad change driven before clock edge k is visible after edge k+1 and not after edge k.
- R4: The trigger field of pin n is bits [2*(n mod 16)+1 : 2*(n mod 16)] of the word at 0x0C for pins 0–15, or of the word at 0x10 for pins 16–31. Its codes are 0 = low level, 1 = high level, 2 = rising edge and 3 = falling edge.
- R5: When bit n of the word at 0x1C is 1, pin n flags on both rising and falling edges and its trigger field has no effect.
- R6: Under a level trigger the status bit is set on every cycle the level persists. A clear while the level is still present leaves the bit set.
- R7: Writing 1 to a bit of the status word at 0x18 clears that bit. Writing 0 leaves it unchanged.
- R8: An event detected in the same cycle as a clear write keeps the status bit set.
- R9: `irq_lo` is high exactly when some pin in 0–15 has both its status bit and its mask bit (word at 0x14, 1 = enabled) set. `irq_hi` follows the same rule for pins 16–31. `irq_any` is the OR of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address. Accesses with the two low bits nonzero are ignored |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, committed at the clock edge |
| bus_re | input | 1 | Read strobe. Read data is zero while it is low |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output register value |
| pad_oe | output | 32 | Per-pin output enable from the direction register |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |
| irq_any | output | 1 | OR of both interrupt lines |

## Verification
A corrupted synchroniser or edge-history flop shows up as a wrong pad readback two edges after a pad change. It also shows as a spurious or missing status bit on the third edge. A wrong trigger decode or a misplaced field leaves one pin's status bit set or clear against its mode within four cycles of a pad transition. The bench therefore sweeps all 32 pins through all five trigger modes, with the mask isolating each pin on its half-port line. A wrong priority between clear and set is visible only when the clear commits on the exact edge where the event is registered, so that cycle is aimed at directly.

// File: rtl/gpio_port_pkg.sv
// Package: shared types for the GPIO port.
// Holds the register index encoding (word offset / 4) and the trigger codes.
package gpio_port_pkg;

    localparam int BUS_ADDR_W = 5;

    typedef enum logic [2:0] {
        IDX_DOUT  = 3'd0,
        IDX_DIR   = 3'd1,
        IDX_PAD   = 3'd2,
        IDX_CFG_L = 3'd3,
        IDX_CFG_H = 3'd4,
        IDX_MASK  = 3'd5,
        IDX_STAT  = 3'd6,
        IDX_BOTH  = 3'd7
    } reg_idx_e;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_e;

endpackage

// File: rtl/gpio_pad_sync.sv
// Module: gpio_pad_sync
// Two-flop synchroniser for a vector of asynchronous pad inputs.
// Assumes the pins are independent; no bus coherency is implied across bits.
module gpio_pad_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_async,
    output logic [WIDTH-1:0] pad_sync
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Two register stages per pin; both clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pad_async;
            sync_q <= meta_q;
        end
    end

    assign pad_sync = sync_q;

endmodule

// File: rtl/gpio_trig_detect.sv
// Module: gpio_trig_detect
// Per-pin trigger detection. It compares the synchronised level against the
// previous sample for edges and uses the level directly for level triggers.
// Assumes the input is already synchronous. The 2-bit fields come packed
// HALF pins per configuration word. A set both-edge bit overrides the field.
module gpio_trig_detect
    import gpio_port_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pad_sync,
    input  logic [PINS-1:0] cfg_lo,
    input  logic [PINS-1:0] cfg_hi,
    input  logic [PINS-1:0] both_sel,
    output logic [PINS-1:0] evt
);

    localparam int HALF = PINS / 2;

    logic [PINS-1:0] prev_q;
    logic [PINS-1:0] rise_w;
    logic [PINS-1:0] fall_w;

    // Edge history: the previous synchronised sample of every pin.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pad_sync;
    end

    assign rise_w = pad_sync & ~prev_q;
    assign fall_w = ~pad_sync & prev_q;

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic [1:0] fld;
        logic       hit;

        if (i < HALF) begin : g_lo
            assign fld = cfg_lo[2*i +: 2];
        end else begin : g_hi
            assign fld = cfg_hi[2*(i-HALF) +: 2];
        end

        // Select the event condition for this pin.
        always_comb begin
            if (both_sel[i]) begin
                hit = rise_w[i] | fall_w[i];
            end else begin
                unique case (trig_e'(fld))
                    TRIG_LOW:  hit = ~pad_sync[i];
                    TRIG_HIGH: hit = pad_sync[i];
                    TRIG_RISE: hit = rise_w[i];
                    TRIG_FALL: hit = fall_w[i];
                    default:   hit = 1'b0;
                endcase
            end
        end

        assign evt[i] = hit;
    end

    // Any change on a both-edge pin must raise an event (R5).
    assert_both_edges_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((both_sel & (pad_sync ^ prev_q) & ~evt) == '0));

    // A level-high pin that sits high always raises an event (R6).
    assert_level_persist_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (cfg_lo[1:0] == 2'd1) && !both_sel[0] && pad_sync[0]) |-> evt[0]);

endmodule

// File: rtl/gpio_irq_status.sv
// Module: gpio_irq_status
// Sticky interrupt status with write-one-to-clear, the enable mask and the
// split of the interrupt lines by half-port. An event in the same cycle as
// a clear wins. Assumes clr_i is already qualified by the bus write strobe.
module gpio_irq_status #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] set_i,
    input  logic [PINS-1:0] clr_i,
    input  logic [PINS-1:0] mask_i,
    output logic [PINS-1:0] status_o,
    output logic            irq_lo,
    output logic            irq_hi,
    output logic            irq_any
);

    localparam int HALF = PINS / 2;

    logic [PINS-1:0] status_q;
    logic [PINS-1:0] pend_w;

    // Status update: clear the written ones, then OR in the new events.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_i) | set_i;
    end

    assign pend_w   = status_q & mask_i;
    assign irq_lo   = |pend_w[HALF-1:0];
    assign irq_hi   = |pend_w[PINS-1:HALF];
    assign irq_any  = irq_lo | irq_hi;
    assign status_o = status_q;

    // Every event of the last cycle is held in status (R8).
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((status_q & $past(set_i)) == $past(set_i)));

    // A cleared bit without a competing event reads zero (R7).
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((status_q & $past(clr_i & ~set_i)) == '0));

    // A raised line needs an enabled pending pin (R9).
    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> ((status_q & mask_i) != '0));

endmodule

// File: rtl/gpio_port_irq.sv
// Module: gpio_port_irq (top)
// 32-pin GPIO port: register file, bus decode, pad synchroniser, trigger
// detection and interrupt status. Register words are at byte offsets
// 0x00..0x1C. Assumes word-aligned accesses; misaligned ones are ignored.
// Reads are combinational and zero while bus_re is low.
module gpio_port_irq
    import gpio_port_pkg::*;
#(
    parameter int PIN_COUNT = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [PIN_COUNT-1:0]  bus_wdata,
    input  logic                  bus_we,
    input  logic                  bus_re,
    output logic [PIN_COUNT-1:0]  bus_rdata,
    input  logic [PIN_COUNT-1:0]  pad_in,
    output logic [PIN_COUNT-1:0]  pad_out,
    output logic [PIN_COUNT-1:0]  pad_oe,
    output logic                  irq_lo,
    output logic                  irq_hi,
    output logic                  irq_any
);

    localparam int W = PIN_COUNT;

    reg_idx_e       idx_w;
    logic           aligned_w;
    logic           wr_hit;
    logic [W-1:0]   dout_q;
    logic [W-1:0]   dir_q;
    logic [W-1:0]   cfg_lo_q;
    logic [W-1:0]   cfg_hi_q;
    logic [W-1:0]   mask_q;
    logic [W-1:0]   both_q;
    logic [W-1:0]   sync_w;
    logic [W-1:0]   evt_w;
    logic [W-1:0]   clr_w;
    logic [W-1:0]   status_w;

    assign idx_w     = reg_idx_e'(bus_addr[BUS_ADDR_W-1:2]);
    assign aligned_w = (bus_addr[1:0] == 2'b00);
    assign wr_hit    = bus_we && aligned_w;

    // Control registers: load the addressed word on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q   <= '0;
            dir_q    <= '0;
            cfg_lo_q <= '0;
            cfg_hi_q <= '0;
            mask_q   <= '0;
            both_q   <= '0;
        end else if (wr_hit) begin
            unique case (idx_w)
                IDX_DOUT:  dout_q   <= bus_wdata;
                IDX_DIR:   dir_q    <= bus_wdata;
                IDX_CFG_L: cfg_lo_q <= bus_wdata;
                IDX_CFG_H: cfg_hi_q <= bus_wdata;
                IDX_MASK:  mask_q   <= bus_wdata;
                IDX_BOTH:  both_q   <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // Clear vector: write data to the status word, otherwise nothing.
    assign clr_w = (wr_hit && idx_w == IDX_STAT) ? bus_wdata : '0;

    gpio_pad_sync #(.WIDTH(W)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_async (pad_in),
        .pad_sync  (sync_w)
    );

    gpio_trig_detect #(.PINS(W)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_sync (sync_w),
        .cfg_lo   (cfg_lo_q),
        .cfg_hi   (cfg_hi_q),
        .both_sel (both_q),
        .evt      (evt_w)
    );

    gpio_irq_status #(.PINS(W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (evt_w),
        .clr_i    (clr_w),
        .mask_i   (mask_q),
        .status_o (status_w),
        .irq_lo   (irq_lo),
        .irq_hi   (irq_hi),
        .irq_any  (irq_any)
    );

    // Read mux: the addressed word, or zero when not reading.
    always_comb begin
        bus_rdata = '0;
        if (bus_re && aligned_w) begin
            unique case (idx_w)
                IDX_DOUT:  bus_rdata = dout_q;
                IDX_DIR:   bus_rdata = dir_q;
                IDX_PAD:   bus_rdata = sync_w;
                IDX_CFG_L: bus_rdata = cfg_lo_q;
                IDX_CFG_H: bus_rdata = cfg_hi_q;
                IDX_MASK:  bus_rdata = mask_q;
                IDX_STAT:  bus_rdata = status_w;
                IDX_BOTH:  bus_rdata = both_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign pad_out = dout_q;
    assign pad_oe  = dir_q;

    // A direction write shows on pad_oe after the edge (R2).
    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && idx_w == IDX_DIR) |=> (pad_oe == $past(bus_wdata)));

    // Nothing reaches the interrupt lines while all pins are masked (R9).
    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_any);

endmodule

// File: tb/test_gpio_port_irq.sv
module test_gpio_port_irq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq_lo, irq_hi, irq_any;

    int n_tests = 0;
    int n_fail  = 0;

    gpio_port_irq i_gpio_port_irq (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write commits at the next posedge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1;
        d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] cfgw;
        logic        bit_v;
        logic [2:0]  irq_exp;

        // R1: reset state, read while reset is held
        wait_cyc(3);
        for (int a = 0; a < 8; a++) begin
            rd(5'(a*4), v);
            check($sformatf("R1 reg %0d", a), v, 32'h0);
        end
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 irqs", {29'h0, irq_any, irq_hi, irq_lo}, 32'h0);
        rst_n = 1'b1;
        wait_cyc(2);

        // R2: output and direction registers
        pad_in = 32'h1234_5678;
        wr(5'h00, 32'hA5A5_0F0F);
        wr(5'h04, 32'hFFFF_0000);
        check("R2 pad_out", pad_out, 32'hA5A5_0F0F);
        check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
        rd(5'h00, v); check("R2 read dout not pad", v, 32'hA5A5_0F0F);
        rd(5'h04, v); check("R2 read dir", v, 32'hFFFF_0000);

        // R3: pad readback through two flops, any direction
        wait_cyc(3);
        pad_in = 32'hDEAD_BEEF;
        @(posedge clk); @(negedge clk);
        rd(5'h08, v); check("R3 after one edge", v, 32'h1234_5678);
        @(posedge clk); @(negedge clk);
        rd(5'h08, v); check("R3 after two edges", v, 32'hDEAD_BEEF);
        pad_in = 32'h0;
        wr(5'h04, 32'h0);
        wait_cyc(4);

        // R4/R5/R6/R9: sweep every pin through every mode
        for (int p = 0; p < 32; p++) begin
            for (int m = 0; m < 5; m++) begin
                cfgw = (m < 4) ? (32'(m) << (2 * (p % 16))) : 32'h0;
                wr(5'h0C, (p < 16) ? cfgw : 32'h0);
                wr(5'h10, (p < 16) ? 32'h0 : cfgw);
                wr(5'h1C, (m == 4) ? (32'h1 << p) : 32'h0);
                wr(5'h14, 32'h1 << p);
                pad_in = 32'h0;
                wait_cyc(4);
                wr(5'h18, 32'h1 << p);
                // R6: low level reasserts at once; R5 field ignored when m==4
                rd(5'h18, v); bit_v = v[p];
                check($sformatf("R6 R5 pin %0d mode %0d after clear low", p, m), 32'(bit_v), 32'(m == 0));
                pad_in[p] = 1'b1;
                wait_cyc(4);
                rd(5'h18, v); bit_v = v[p];
                check($sformatf("R4 pin %0d mode %0d after rise", p, m), 32'(bit_v), 32'(m != 3));
                irq_exp = {bit_v, bit_v && p >= 16, bit_v && p < 16};
                check($sformatf("R9 pin %0d mode %0d irq", p, m), {29'h0, irq_any, irq_hi, irq_lo}, {29'h0, irq_exp});
                wr(5'h18, 32'h1 << p);
                rd(5'h18, v); bit_v = v[p];
                check($sformatf("R6 pin %0d mode %0d clear high", p, m), 32'(bit_v), 32'(m == 1));
                pad_in[p] = 1'b0;
                wait_cyc(4);
                rd(5'h18, v); bit_v = v[p];
                check($sformatf("R4 pin %0d mode %0d after fall", p, m), 32'(bit_v), 32'(m != 2));
                irq_exp = {bit_v, bit_v && p >= 16, bit_v && p < 16};
                check($sformatf("R9 pin %0d mode %0d irq fall", p, m), {29'h0, irq_any, irq_hi, irq_lo}, {29'h0, irq_exp});
            end
        end

        // R7: write-one-to-clear with rising triggers on every pin
        wr(5'h1C, 32'h0);
        wr(5'h0C, 32'hAAAA_AAAA);
        wr(5'h10, 32'hAAAA_AAAA);
        wr(5'h14, 32'h0);
        wait_cyc(4);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, v); check("R7 clear all", v, 32'h0);
        pad_in = 32'h0000_00FF;
        wait_cyc(4);
        rd(5'h18, v); check("R7 events set", v, 32'h0000_00FF);
        check("R9 masked quiet", {29'h0, irq_any, irq_hi, irq_lo}, 32'h0);
        wr(5'h14, 32'hFFFF_0000);
        check("R9 other half mask", {29'h0, irq_any, irq_hi, irq_lo}, 32'h0);
        wr(5'h18, 32'h0);
        rd(5'h18, v); check("R7 zero write keeps", v, 32'h0000_00FF);
        wr(5'h18, 32'h0000_000F);
        rd(5'h18, v); check("R7 partial clear", v, 32'h0000_00F0);
        wr(5'h14, 32'h0000_0010);
        check("R9 low line", {29'h0, irq_any, irq_hi, irq_lo}, 32'h5);

        // R8: clear in the same cycle as the registered rising edge
        pad_in = 32'h0;
        wait_cyc(4);
        wr(5'h18, 32'hFFFF_FFFF);
        pad_in[8] = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        wr(5'h18, 32'h0000_0100);
        rd(5'h18, v); check("R8 event beats clear", v, 32'h0000_0100);
        wr(5'h18, 32'hFFFF_FFFF);
        pad_in[9] = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        wr(5'h18, 32'h0000_0200);
        rd(5'h18, v); check("R8 R7 clear one cycle later", v, 32'h0);

        finish_run();
    end

endmodule